// File: doc/BRIEF.md
# Oscillator-Based Entropy Collector

The block gathers raw noise from two groups of free-running oscillators and packs it into 32-bit entropy words that software reads over a small read-only register bus. Each oscillator group arrives as a plain vector of asynchronous bits. The block synchronizes each vector, reduces it with XOR to a single bit, and latches both group bits together on a fixed sampling interval. The group bits from two consecutive sampling events are folded into one entropy bit. That bit then shifts into a 32-bit collection register.

Collection runs without pause. Bits that software has not read are pushed out as new bits arrive, so a read always returns the latest 32 bits. A status flag signals that enough fresh bits have gathered since the previous word read. Setting that threshold at twice the word width means two words read in turn are separated by at least 32 discarded bits. Software should treat the output as seed material for a deterministic generator and should not use it as final random data.

Top module: `entropy_collector`

## Requirements
- R1: Each oscillator group passes through a two-stage synchronizer and is then XOR-reduced to one bit. Both group bits are latched together on the SAMPLE_INTERVAL-th clock edge after reset and on every SAMPLE_INTERVAL-th edge after that.
- R2: Sampling events pair up from reset as (first, second), (third, fourth), and so on. Each pair yields one entropy bit equal to the XOR of all four latched group bits. The bit enters the collection register one cycle after the second event of the pair is latched.
- R3: A new entropy bit enters at bit 0 of the collection register, and older bits move one place toward bit 31. Reading address 0x20 returns the whole 32-bit register.
- R4: The ready flag rises once READY_THRESHOLD new bits have been collected since reset or since the last read of address 0x20. The new-bit count saturates at that threshold.
- R5: A read of address 0x20 clears the ready flag and restarts the new-bit count from zero. The flag then stays low until READY_THRESHOLD further bits have arrived.
- R6: A read of address 0x09 returns the ready flag in bit 0 and zero in bits 31 to 1.
- R7: A read of any address other than 0x09 or 0x20 returns zero. When bus_cs is low, bus_rdata is zero.
- R8: Bus writes (bus_cs and bus_we high) change neither the ready flag, the new-bit count nor the collection register, and return zero on bus_rdata.
- R9: Reset clears the collection register, the sample counter, the pairing phase, the new-bit count and the ready flag.
- R10: Consecutive sampling events are exactly SAMPLE_INTERVAL cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_grp_a | input | GROUP_WIDTH | Raw bits of oscillator group A (asynchronous) |
| osc_grp_b | input | GROUP_WIDTH | Raw bits of oscillator group B (asynchronous) |
| bus_cs | input | 1 | Bus select |
| bus_we | input | 1 | Write strobe; writes are ignored |
| bus_addr | input | 8 | Register address |
| bus_rdata | output | 32 | Read data, combinational from the address |

## Verification
The oscillator inputs are first driven with directed patterns: both groups all zero, both all ones, a single set bit at either end of one group, and alternating bits in opposite phase. These patterns separate a correct XOR reduction and pairing from a bit order that is swapped, a group that is lost, or a phase that is off by one. Pseudo-random group vectors then fill many words, so a comparison of every word read with a bench model of the fold-and-shift finds any wrong shift direction or wrong pairing. Random bus traffic mixes status reads, rare early word reads, writes and reads of unused addresses. This traffic shows whether the ready flag tracks the threshold count exactly and whether writes and stray addresses leave the state alone.

// File: rtl/entcol_pkg.sv
package entcol_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;
  localparam logic [BUS_AW-1:0] REG_STATUS = 8'h09;
  localparam logic [BUS_AW-1:0] REG_WORD   = 8'h20;

  typedef struct packed {
    logic grp_a;
    logic grp_b;
  } pair_t;
endpackage

// File: rtl/entcol_sync_fold.sv
module entcol_sync_fold #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic             folded
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= raw;
      stab_q <= meta_q;
    end
  end

  assign folded = ^stab_q;
endmodule

// File: rtl/entcol_timer.sv
module entcol_timer #(
  parameter int unsigned INTERVAL = 4096
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/entcol_collector.sv
module entcol_collector
  import entcol_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned THRESH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  pair_t             fold_in,
  input  logic              clr,
  output logic [WORD_W-1:0] word,
  output logic              ready,
  output logic              shift_en
);
  localparam int unsigned CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  pair_t             samp_q, samp_d;
  logic              vld_q;
  logic              phase_q, phase_d;
  logic              first_q, first_d;
  logic              pair_fold, new_bit;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ready_q, ready_d;

  always_comb begin
    samp_d    = tick ? fold_in : samp_q;
    pair_fold = samp_q.grp_a ^ samp_q.grp_b;
    shift_en  = vld_q & phase_q;
    phase_d   = vld_q ? ~phase_q : phase_q;
    first_d   = (vld_q & ~phase_q) ? pair_fold : first_q;
    new_bit   = first_q ^ pair_fold;
    word_d    = shift_en ? {word_q[WORD_W-2:0], new_bit} : word_q;
    if (clr) begin
      cnt_d = shift_en ? CNT_ONE : '0;
    end else if (shift_en && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    ready_d = (cnt_d == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      vld_q   <= 1'b0;
      phase_q <= 1'b0;
      first_q <= 1'b0;
      word_q  <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      vld_q   <= tick;
      phase_q <= phase_d;
      first_q <= first_d;
      word_q  <= word_d;
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

  assign word  = word_q;
  assign ready = ready_q;
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import entcol_pkg::*;
#(
  parameter int unsigned SAMPLE_INTERVAL = 4096,
  parameter int unsigned GROUP_WIDTH     = 16,
  parameter int unsigned READY_THRESHOLD = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GROUP_WIDTH-1:0] osc_grp_a,
  input  logic [GROUP_WIDTH-1:0] osc_grp_b,
  input  logic                   bus_cs,
  input  logic                   bus_we,
  input  logic [BUS_AW-1:0]      bus_addr,
  output logic [BUS_DW-1:0]      bus_rdata
);
  localparam int unsigned N_GROUPS = 2;

  logic [N_GROUPS-1:0][GROUP_WIDTH-1:0] osc_arr;
  logic [N_GROUPS-1:0]                  folded;
  pair_t                                fold_pair;
  logic                                 sample_tick;
  logic                                 shift_en;
  logic                                 ready_flag;
  logic [BUS_DW-1:0]                    coll_word;
  logic                                 rd_en, rd_word, rd_status;

  assign osc_arr[0] = osc_grp_a;
  assign osc_arr[1] = osc_grp_b;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    entcol_sync_fold #(.WIDTH(GROUP_WIDTH)) u_fold (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (osc_arr[g]),
      .folded (folded[g])
    );
  end

  assign fold_pair.grp_a = folded[0];
  assign fold_pair.grp_b = folded[1];

  entcol_timer #(.INTERVAL(SAMPLE_INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sample_tick)
  );

  always_comb begin
    rd_en     = bus_cs & ~bus_we;
    rd_word   = rd_en & (bus_addr == REG_WORD);
    rd_status = rd_en & (bus_addr == REG_STATUS);
  end

  entcol_collector #(.WORD_W(BUS_DW), .THRESH(READY_THRESHOLD)) u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sample_tick),
    .fold_in  (fold_pair),
    .clr      (rd_word),
    .word     (coll_word),
    .ready    (ready_flag),
    .shift_en (shift_en)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_status)    bus_rdata[0] = ready_flag;
    else if (rd_word) bus_rdata    = coll_word;
  end
endmodule

// File: rtl/entropy_collector_chk.sv
module entropy_collector_chk #(
  parameter int unsigned INTERVAL = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        tick,
  input logic        shift_en,
  input logic        ready,
  input logic [31:0] word
);
  logic [31:0] gap_q;
  logic        rd_w, rd_s, rd_other;

  assign rd_w     = bus_cs && !bus_we && (bus_addr == 8'h20);
  assign rd_s     = bus_cs && !bus_we && (bus_addr == 8'h09);
  assign rd_other = bus_cs && !bus_we && (bus_addr != 8'h20) && (bus_addr != 8'h09);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= tick ? '0 : gap_q + 1;
  end

  assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == INTERVAL - 1));

  assert_shift_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> $past(tick));

  assert_word_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));

  assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(shift_en));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_w |=> !ready);

  assert_status_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s |-> (bus_rdata == {31'b0, ready}));

  assert_other_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs || rd_other) |-> (bus_rdata == 32'b0));

  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we && !shift_en) |=> ($stable(ready) && $stable(word)));
endmodule

bind entropy_collector entropy_collector_chk #(.INTERVAL(SAMPLE_INTERVAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs    (bus_cs),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tick      (sample_tick),
  .shift_en  (shift_en),
  .ready     (ready_flag),
  .word      (coll_word)
);

// File: tb/sim_entropy_collector.sv
`timescale 1ns/1ps
module sim_entropy_collector;
  localparam int IVL   = 16;
  localparam int GRP   = 16;
  localparam int THR   = 64;
  localparam int NSLOT = 600;

  localparam int K_IDLE = 0;
  localparam int K_RD   = 1;
  localparam int K_WR   = 2;

  logic           clk;
  logic           rst_n;
  logic [GRP-1:0] osc_a, osc_b;
  logic           cs, we;
  logic [7:0]     addr;
  logic [31:0]    rdata;

  int n_chk;
  int n_err;

  logic [31:0] m_word;
  int          m_cnt;
  logic        m_ready;
  logic        pend;
  logic        have_bit;
  logic        bit_val;

  entropy_collector #(
    .SAMPLE_INTERVAL (IVL),
    .GROUP_WIDTH     (GRP),
    .READY_THRESHOLD (THR)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_grp_a (osc_a),
    .osc_grp_b (osc_b),
    .bus_cs    (cs),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_rdata (rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic fold_of(input logic [GRP-1:0] a, input logic [GRP-1:0] b);
    return (^a) ^ (^b);
  endfunction

  // Model of R3/R4: shift a bit in and count fresh bits.
  task automatic model_shift(input logic b);
    m_word = {m_word[30:0], b};
    if (m_cnt < THR) m_cnt++;
    if (m_cnt >= THR) m_ready = 1'b1;
  endtask

  function automatic logic [31:0] expect_read(input int kind, input logic [7:0] a);
    if (kind != K_RD) return 32'h0;
    if (a == 8'h09) return {31'b0, m_ready};
    if (a == 8'h20) return m_word;
    return 32'h0;
  endfunction

  // One bus operation spanning exactly one rising edge; starts and ends at a falling edge.
  task automatic bus_op(input int kind, input logic [7:0] a, input string req);
    cs   = (kind != K_IDLE);
    we   = (kind == K_WR);
    addr = a;
    #1;
    check(req, rdata, expect_read(kind, a));
    @(posedge clk);
    if (kind == K_RD && a == 8'h20) begin
      m_cnt   = 0;
      m_ready = 1'b0;
    end
    @(negedge clk);
    cs = 1'b0;
    we = 1'b0;
  endtask

  task automatic set_osc(input int e);
    case (e)
      0: begin osc_a = '0;          osc_b = '0;          end
      1: begin osc_a = '1;          osc_b = '1;          end
      2: begin osc_a = 16'h0001;    osc_b = 16'h0000;    end
      3: begin osc_a = 16'h0000;    osc_b = 16'h8000;    end
      4: begin osc_a = 16'haaaa;    osc_b = 16'h5554;    end
      5: begin osc_a = 16'h8000;    osc_b = 16'h0000;    end
      default: begin osc_a = GRP'($urandom); osc_b = GRP'($urandom); end
    endcase
  endtask

  function automatic logic [7:0] other_addr();
    logic [7:0] v;
    v = 8'($urandom);
    if (v == 8'h09 || v == 8'h20) v = 8'h21;
    return v;
  endfunction

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    void'($urandom(32'h1d5e_a7c3));
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0;
    osc_a = '0; osc_b = '0;
    m_word = '0; m_cnt = 0; m_ready = 1'b0; pend = 1'b0; have_bit = 1'b0; bit_val = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: cleared state visible through the bus while in reset
    cs = 1'b1; addr = 8'h09; #1; check("R9 status", rdata, 32'h0);
    addr = 8'h20; #1; check("R9 word", rdata, 32'h0);
    cs = 1'b0; addr = '0; #1; check("R7 idle", rdata, 32'h0);
    @(negedge clk);

    for (int e = 0; e < NSLOT; e++) begin
      set_osc(e);
      if (e == 0) rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (have_bit) begin
        model_shift(bit_val);
        have_bit = 1'b0;
      end
      if (e == 0) begin
        bus_op(K_RD, 8'h09, "R9 after release");
        bus_op(K_RD, 8'h20, "R9 R3 word after release");
      end else if (e == 5 || e == 9) begin
        // early word reads: R1 R2 directed patterns land in low word bits
        bus_op(K_RD, 8'h20, "R1 R2 R3 early word");
        bus_op(K_RD, 8'h09, "R5 status after read");
      end else begin
        int pick;
        pick = int'($urandom % 100);
        if ((m_ready && pick < 30) || pick == 99) begin
          bus_op(K_RD, 8'h20, "R2 R3 word");
          bus_op(K_RD, 8'h09, "R5 status after read");
        end else if (pick < 55) begin
          bus_op(K_RD, 8'h09, "R4 R6 status");
          bus_op(K_IDLE, 8'h20, "R7 deselected");
        end else if (pick < 75) begin
          bus_op(K_WR, (pick[0] ? 8'h20 : 8'h09), "R8 write data");
          bus_op(K_RD, 8'h09, "R8 status after write");
        end else begin
          bus_op(K_RD, other_addr(), "R7 other address");
          bus_op(K_RD, 8'h09, "R4 R6 status");
        end
      end
      // R1 R10: event e is latched at the end of this slot
      if (e % 2 == 0) begin
        pend = fold_of(osc_a, osc_b);
      end else begin
        bit_val  = pend ^ fold_of(osc_a, osc_b);
        have_bit = 1'b1;
      end
      repeat (IVL - 3) @(posedge clk);
      @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule